// File: doc/BRIEF.md
# Shared-Memory Host Bridge

This block sits between a host bus and a user application core and keeps the two apart. The host never reaches the core's logic. Every exchange goes through storage inside the bridge: a bank of 32 registers, each 32 bits wide (1024 bits in all), and a 4 KB two-port RAM. Both are decoded from one host word address.

The core has its own ports into the same registers and RAM. It uses them in the same cycles as the host, with fixed latencies.

The host bus is a plain word-addressed read/write interface. It returns read data with a one-cycle strobe whose delay depends only on the region addressed. The most significant address bit picks the region. The region that each value of that bit selects, the register count and the RAM size are all parameters, so the map can be rearranged. One word just above the register words holds a sticky flag. The flag records a same-cycle write by both sides to the same register. Software reads the flag and clears it.

Top module: `shmw_top`

## Requirements
- R1: After reset, `h_rvalid` is low, every register word reads 0 and the collision flag reads 0.
- R2: A host read with address bit 10 = 0 and offset 0..31 raises `h_rvalid` exactly one cycle after the request. The strobe carries the last value written to that register word.
- R3: A host read with address bit 10 = 1 (offset 0..1023 is the RAM word) raises `h_rvalid` exactly two cycles after the request with the stored word. Host reads may be issued back to back, and responses return in issue order. A register-side read must not follow a RAM read in the very next cycle.
- R4: A core RAM read raises `core_ram_rvalid` with the data exactly two cycles after the request, and not one cycle after it. A core RAM write is seen by a core read issued in the following cycle.
- R5: Storage is shared. Host writes are visible to the core and core writes are visible to the host, for registers and for RAM. `core_reg_rdata` shows the word addressed by `core_reg_addr` one cycle earlier.
- R6: If host and core write the same register word in the same cycle, the core's data is kept and the collision flag becomes 1. Same-cycle writes to different words both take effect and leave the flag at 0.
- R7: The collision flag is bit 0 of register-side offset 32 (other bits read 0). It stays set until a host write to that offset with data bit 0 = 1 clears it. A write there with bit 0 = 0, or any other write, leaves it unchanged.
- R8: If host and core write the same RAM word in the same cycle, the core's data is stored.
- R9: A read of a register or RAM word in the same cycle as a write to that word returns the content held before the write.
- R10: Register-side offsets 33..1023 read 0 with the one-cycle register latency. Writes to them change nothing; offset 64 does not alias word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_addr | input | 11 | Host word address; bit 10 selects RAM (1) or registers (0) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, qualified by h_rvalid |
| h_rvalid | output | 1 | Host read data strobe |
| core_reg_we | input | 1 | Core register write enable |
| core_reg_addr | input | 5 | Core register word index, for write and read |
| core_reg_wdata | input | 32 | Core register write data |
| core_reg_rdata | output | 32 | Word addressed in the previous cycle |
| core_ram_req | input | 1 | Core RAM access request |
| core_ram_we | input | 1 | Core RAM write (with req) |
| core_ram_addr | input | 10 | Core RAM word index |
| core_ram_wdata | input | 32 | Core RAM write data |
| core_ram_rdata | output | 32 | Core RAM read data, qualified by core_ram_rvalid |
| core_ram_rvalid | output | 1 | Core RAM read data strobe |

## Verification
A read pipeline flag that is lost, duplicated or delayed shows on the very next expected strobe. The bench ties each response to the exact cycle it is due, so a strobe one cycle early or late is reported immediately.

A wrong write priority or a stuck collision flag only appears when the word or the status offset is read back. That happens one or two cycles after the contested write.

A decode error that aliases out-of-range offsets onto real words stays hidden until the aliased word is read. For that reason, a real word is read right after each stray write.

// File: rtl/shmw_pkg.sv
package shmw_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_COUNT = 32;
    localparam int RAM_BYTES = 4096;
    localparam int HADDR_W   = 11;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_REG  = 2'd1,
        RGN_STAT = 2'd2,
        RGN_RAM  = 2'd3
    } region_e;
endpackage

// File: rtl/shmw_decode.sv
module shmw_decode
    import shmw_pkg::*;
#(
    parameter int HA_W      = 11,
    parameter int REG_WORDS = 32,
    parameter int RAM_WORDS = 1024,
    parameter int STAT_OFF  = 32,
    parameter bit RAM_SEL   = 1'b1
) (
    input  logic [HA_W-1:0]                  addr,
    output region_e                          rgn,
    output logic                             ram_side,
    output logic [$clog2(REG_WORDS)-1:0]     reg_idx,
    output logic [$clog2(RAM_WORDS)-1:0]     ram_idx
);
    localparam int OW = HA_W - 1;
    localparam int RG_W = $clog2(REG_WORDS);
    localparam int RA_W = $clog2(RAM_WORDS);
    localparam logic [OW:0] REG_LIM = (OW+1)'(REG_WORDS);
    localparam logic [OW:0] RAM_LIM = (OW+1)'(RAM_WORDS);
    localparam logic [OW:0] STAT_AT = (OW+1)'(STAT_OFF);

    logic [OW-1:0] off;

    always_comb begin
        off      = addr[OW-1:0];
        ram_side = (addr[OW] == RAM_SEL);
        reg_idx  = off[RG_W-1:0];
        ram_idx  = off[RA_W-1:0];
        rgn      = RGN_NONE;
        if (ram_side) begin
            if ({1'b0, off} < RAM_LIM) rgn = RGN_RAM;
        end else if ({1'b0, off} < REG_LIM) begin
            rgn = RGN_REG;
        end else if ({1'b0, off} == STAT_AT) begin
            rgn = RGN_STAT;
        end
    end
endmodule

// File: rtl/shmw_regbank.sv
module shmw_regbank #(
    parameter int DW        = 32,
    parameter int REG_WORDS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         h_we,
    input  logic [$clog2(REG_WORDS)-1:0] h_idx,
    input  logic [DW-1:0]                h_wdata,
    output logic [DW-1:0]                h_rdata,
    input  logic                         c_we,
    input  logic [$clog2(REG_WORDS)-1:0] c_idx,
    input  logic [DW-1:0]                c_wdata,
    output logic [DW-1:0]                c_rdata,
    input  logic                         clr,
    output logic                         coll
);
    typedef struct packed {
        logic [REG_WORDS-1:0][DW-1:0] words;
        logic [DW-1:0]                crd;
        logic                         coll;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  same_word;

    always_comb begin
        bank_d    = bank_q;
        same_word = h_we && c_we && (h_idx == c_idx);
        if (h_we) bank_d.words[h_idx] = h_wdata;
        if (c_we) bank_d.words[c_idx] = c_wdata;
        bank_d.crd = bank_q.words[c_idx];
        if (clr) bank_d.coll = 1'b0;
        if (same_word) bank_d.coll = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign h_rdata = bank_q.words[h_idx];
    assign c_rdata = bank_q.crd;
    assign coll    = bank_q.coll;

    // R6: core data survives a same-word clash
    p_core_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && c_we && h_idx == c_idx) |=> (bank_q.words[$past(c_idx)] == $past(c_wdata)));
    // R6: clash raises the flag
    p_coll_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && c_we && h_idx == c_idx) |=> coll);
    // R7: flag only drops on a clear request
    p_coll_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !clr) |=> coll);
endmodule

// File: rtl/shmw_dpram.sv
module shmw_dpram #(
    parameter int DW    = 32,
    parameter int WORDS = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     a_we,
    input  logic [$clog2(WORDS)-1:0] a_addr,
    input  logic [DW-1:0]            a_wdata,
    output logic [DW-1:0]            a_rdata,
    input  logic                     b_we,
    input  logic [$clog2(WORDS)-1:0] b_addr,
    input  logic [DW-1:0]            b_wdata,
    output logic [DW-1:0]            b_rdata
);
    typedef struct packed {
        logic [DW-1:0] a_out;
        logic [DW-1:0] b_out;
    } stage_t;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] a_s1, b_s1;
    stage_t        stg_d, stg_q;

    // array and first read stage: no reset on storage
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_s1 <= mem[a_addr];
        b_s1 <= mem[b_addr];
    end

    always_comb begin
        stg_d       = stg_q;
        stg_d.a_out = a_s1;
        stg_d.b_out = b_s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign a_rdata = stg_q.a_out;
    assign b_rdata = stg_q.b_out;

    // R8: port B write wins on the same word
    p_bwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we && a_addr == b_addr) |=> (mem[$past(b_addr)] == $past(b_wdata)));
endmodule

// File: rtl/shmw_top.sv
module shmw_top
    import shmw_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int REG_WORDS = REG_COUNT,
    parameter int RAM_BYTES_P = RAM_BYTES,
    parameter int HA_W      = HADDR_W,
    parameter bit RAM_SEL   = 1'b1,
    parameter int STAT_OFF  = REG_COUNT
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    h_rd,
    input  logic                                    h_wr,
    input  logic [HA_W-1:0]                         h_addr,
    input  logic [DW-1:0]                           h_wdata,
    output logic [DW-1:0]                           h_rdata,
    output logic                                    h_rvalid,
    input  logic                                    core_reg_we,
    input  logic [$clog2(REG_WORDS)-1:0]            core_reg_addr,
    input  logic [DW-1:0]                           core_reg_wdata,
    output logic [DW-1:0]                           core_reg_rdata,
    input  logic                                    core_ram_req,
    input  logic                                    core_ram_we,
    input  logic [$clog2(RAM_BYTES_P/(DW/8))-1:0]   core_ram_addr,
    input  logic [DW-1:0]                           core_ram_wdata,
    output logic [DW-1:0]                           core_ram_rdata,
    output logic                                    core_ram_rvalid
);
    localparam int RAM_WORDS = RAM_BYTES_P / (DW / 8);
    localparam int RG_W      = $clog2(REG_WORDS);
    localparam int RA_W      = $clog2(RAM_WORDS);

    typedef struct packed {
        logic          rrsp_vld;
        logic [DW-1:0] rrsp_data;
        logic          hram1_vld;
        logic          hram1_ok;
        logic          hram2_vld;
        logic          hram2_ok;
        logic          cram1_vld;
        logic          cram2_vld;
    } pipe_t;

    pipe_t           pipe_d, pipe_q;
    region_e         rgn;
    logic            ram_side;
    logic [RG_W-1:0] h_reg_idx;
    logic [RA_W-1:0] h_ram_idx;
    logic [DW-1:0]   rb_hrdata, ram_a_rdata;
    logic            coll;
    logic            reg_hwe, ram_hwe, stat_clr;

    shmw_decode #(
        .HA_W(HA_W), .REG_WORDS(REG_WORDS), .RAM_WORDS(RAM_WORDS),
        .STAT_OFF(STAT_OFF), .RAM_SEL(RAM_SEL)
    ) u_dec (
        .addr(h_addr), .rgn(rgn), .ram_side(ram_side),
        .reg_idx(h_reg_idx), .ram_idx(h_ram_idx)
    );

    always_comb begin
        reg_hwe  = h_wr && (rgn == RGN_REG);
        ram_hwe  = h_wr && (rgn == RGN_RAM);
        stat_clr = h_wr && (rgn == RGN_STAT) && h_wdata[0];
    end

    shmw_regbank #(.DW(DW), .REG_WORDS(REG_WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .h_we(reg_hwe), .h_idx(h_reg_idx), .h_wdata(h_wdata), .h_rdata(rb_hrdata),
        .c_we(core_reg_we), .c_idx(core_reg_addr), .c_wdata(core_reg_wdata),
        .c_rdata(core_reg_rdata), .clr(stat_clr), .coll(coll)
    );

    shmw_dpram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .a_we(ram_hwe), .a_addr(h_ram_idx), .a_wdata(h_wdata), .a_rdata(ram_a_rdata),
        .b_we(core_ram_req && core_ram_we), .b_addr(core_ram_addr),
        .b_wdata(core_ram_wdata), .b_rdata(core_ram_rdata)
    );

    always_comb begin
        pipe_d           = pipe_q;
        pipe_d.rrsp_vld  = h_rd && !ram_side;
        unique case (rgn)
            RGN_REG:  pipe_d.rrsp_data = rb_hrdata;
            RGN_STAT: pipe_d.rrsp_data = {{(DW-1){1'b0}}, coll};
            default:  pipe_d.rrsp_data = '0;
        endcase
        pipe_d.hram1_vld = h_rd && ram_side;
        pipe_d.hram1_ok  = (rgn == RGN_RAM);
        pipe_d.hram2_vld = pipe_q.hram1_vld;
        pipe_d.hram2_ok  = pipe_q.hram1_ok;
        pipe_d.cram1_vld = core_ram_req && !core_ram_we;
        pipe_d.cram2_vld = pipe_q.cram1_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    always_comb begin
        h_rvalid = pipe_q.rrsp_vld || pipe_q.hram2_vld;
        if (pipe_q.rrsp_vld)      h_rdata = pipe_q.rrsp_data;
        else if (pipe_q.hram2_ok) h_rdata = ram_a_rdata;
        else                      h_rdata = '0;
        core_ram_rvalid = pipe_q.cram2_vld;
    end

    // R2: register-side reads answer after one cycle
    p_reg_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !ram_side) |=> h_rvalid);
    // R3: RAM-side reads answer after two cycles
    p_ram_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && ram_side) |=> ##1 h_rvalid);
    // R3: host protocol, no register read right after a RAM read
    p_no_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && ram_side) |=> !(h_rd && !ram_side));
    // R4: core RAM read latency
    p_core_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ram_req && !core_ram_we) |=> ##1 core_ram_rvalid);
    // R10: stray register-side offsets read zero
    p_oor_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !ram_side && rgn == RGN_NONE) |=> (h_rdata == '0));
endmodule

// File: tb/sim_shmw_top.sv
`timescale 1ns/1ps
module sim_shmw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_rd = 1'b0, h_wr = 1'b0;
    logic [10:0] h_addr = '0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic        h_rvalid;
    logic        core_reg_we = 1'b0;
    logic [4:0]  core_reg_addr = '0;
    logic [31:0] core_reg_wdata = '0, core_reg_rdata;
    logic        core_ram_req = 1'b0, core_ram_we = 1'b0;
    logic [9:0]  core_ram_addr = '0;
    logic [31:0] core_ram_wdata = '0, core_ram_rdata;
    logic        core_ram_rvalid;

    int n_vec = 0, n_err = 0, cyc = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shmw_top u0 (
        .clk(clk), .rst_n(rst_n), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .core_reg_we(core_reg_we), .core_reg_addr(core_reg_addr),
        .core_reg_wdata(core_reg_wdata), .core_reg_rdata(core_reg_rdata),
        .core_ram_req(core_ram_req), .core_ram_we(core_ram_we),
        .core_ram_addr(core_ram_addr), .core_ram_wdata(core_ram_wdata),
        .core_ram_rdata(core_ram_rdata), .core_ram_rvalid(core_ram_rvalid)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected host responses and compares data and cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (h_rvalid) begin
                if (exp_q.size() == 0) begin
                    check("R2/R3 unexpected h_rvalid", 32'd1, 32'd0);
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic int d = due_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check({t, " data"}, h_rdata, e);
                    check({t, " cycle"}, 32'(cyc), 32'(d));
                end
            end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
                check({tag_q[0], " missing h_rvalid"}, 32'd0, 32'd1);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
        end
    end

    task automatic host_rd(logic [10:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        due_q.push_back(cyc + (a[10] ? 2 : 1));
        tag_q.push_back(tag);
        h_rd = 1'b1; h_addr = a;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic host_wr(logic [10:0] a, logic [31:0] d);
        h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic core_reg_wr(logic [4:0] a, logic [31:0] d);
        core_reg_we = 1'b1; core_reg_addr = a; core_reg_wdata = d;
        @(negedge clk);
        core_reg_we = 1'b0;
    endtask

    task automatic core_reg_rd(logic [4:0] a, logic [31:0] e, string tag);
        core_reg_addr = a;
        @(negedge clk);
        check(tag, core_reg_rdata, e);
    endtask

    task automatic core_ram_wr(logic [9:0] a, logic [31:0] d);
        core_ram_req = 1'b1; core_ram_we = 1'b1; core_ram_addr = a; core_ram_wdata = d;
        @(negedge clk);
        core_ram_req = 1'b0; core_ram_we = 1'b0;
    endtask

    task automatic core_ram_rd(logic [9:0] a, logic [31:0] e, string tag);
        core_ram_req = 1'b1; core_ram_we = 1'b0; core_ram_addr = a;
        @(negedge clk);
        core_ram_req = 1'b0;
        check({tag, " early rvalid"}, 32'(core_ram_rvalid), 32'd0);
        @(negedge clk);
        check({tag, " rvalid"}, 32'(core_ram_rvalid), 32'd1);
        check({tag, " data"}, core_ram_rdata, e);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [10:0] STAT = 11'd32;

    initial begin
        gap(3);
        check("R1 h_rvalid in reset", 32'(h_rvalid), 32'd0);
        rst_n = 1'b1;
        gap(1);
        check("R1 h_rvalid after reset", 32'(h_rvalid), 32'd0);
        host_rd(11'd3, 32'h0, "R1 reg3 reset value"); gap(1);
        host_rd(STAT, 32'h0, "R1 flag reset value"); gap(1);

        // R2 host register path, boundary words
        host_wr(11'd3, 32'hA5A5_0003);
        host_wr(11'd31, 32'h3131_3131);
        host_rd(11'd3, 32'hA5A5_0003, "R2 reg3");
        host_rd(11'd31, 32'h3131_3131, "R2 reg31"); gap(1);

        // R3 host RAM path, ends of the array, back to back reads
        host_wr(11'd1024, 32'h0000_BEEF);
        host_wr(11'd2047, 32'hFFFF_0001);
        host_rd(11'd1024, 32'h0000_BEEF, "R3 ram0");
        host_rd(11'd2047, 32'hFFFF_0001, "R3 ram1023"); gap(3);

        // R5 sharing in both directions
        core_reg_rd(5'd3, 32'hA5A5_0003, "R5 core sees host reg3");
        core_reg_wr(5'd7, 32'h0000_0777);
        host_rd(11'd7, 32'h0000_0777, "R5 host sees core reg7"); gap(1);
        core_ram_rd(10'd1023, 32'hFFFF_0001, "R5 core sees host ram1023");
        core_ram_wr(10'd500, 32'h0500_0500);
        host_rd(11'd1524, 32'h0500_0500, "R5 host sees core ram500"); gap(3);

        // R4 core write followed at once by core read
        core_ram_wr(10'd600, 32'h6006_6006);
        core_ram_rd(10'd600, 32'h6006_6006, "R4 core write then read");

        // R6 different words in one cycle: both kept, no flag
        h_wr = 1'b1; h_addr = 11'd10; h_wdata = 32'h1010_1010;
        core_reg_we = 1'b1; core_reg_addr = 5'd11; core_reg_wdata = 32'h1111_1111;
        @(negedge clk); h_wr = 1'b0; core_reg_we = 1'b0;
        host_rd(11'd10, 32'h1010_1010, "R6 host word kept"); gap(1);
        host_rd(11'd11, 32'h1111_1111, "R6 core word kept"); gap(1);
        host_rd(STAT, 32'h0, "R6 no flag on distinct words"); gap(1);

        // R6 same word in one cycle: core wins, flag set
        h_wr = 1'b1; h_addr = 11'd9; h_wdata = 32'hAAAA_0009;
        core_reg_we = 1'b1; core_reg_addr = 5'd9; core_reg_wdata = 32'hCCCC_0009;
        @(negedge clk); h_wr = 1'b0; core_reg_we = 1'b0;
        host_rd(11'd9, 32'hCCCC_0009, "R6 core data wins"); gap(1);
        host_rd(STAT, 32'h1, "R6 flag set"); gap(1);

        // R7 stickiness and clearing
        host_wr(STAT, 32'hFFFF_FFFE);
        host_rd(STAT, 32'h1, "R7 bit0=0 write keeps flag"); gap(1);
        host_wr(11'd12, 32'h0000_0012);
        host_rd(STAT, 32'h1, "R7 other write keeps flag"); gap(1);
        host_wr(STAT, 32'h0000_0001);
        host_rd(STAT, 32'h0, "R7 clear"); gap(1);

        // R8 same RAM word in one cycle: core wins
        h_wr = 1'b1; h_addr = 11'd1724; h_wdata = 32'hAAAA_0700;
        core_ram_req = 1'b1; core_ram_we = 1'b1; core_ram_addr = 10'd700; core_ram_wdata = 32'hCCCC_0700;
        @(negedge clk); h_wr = 1'b0; core_ram_req = 1'b0; core_ram_we = 1'b0;
        host_rd(11'd1724, 32'hCCCC_0700, "R8 core RAM data wins"); gap(3);

        // R9 read during write returns old content
        host_wr(11'd1824, 32'h0000_0800);
        h_wr = 1'b1; h_addr = 11'd1824; h_wdata = 32'h0000_0801;
        core_ram_req = 1'b1; core_ram_we = 1'b0; core_ram_addr = 10'd800;
        @(negedge clk); h_wr = 1'b0; core_ram_req = 1'b0;
        @(negedge clk);
        check("R9 core RAM read old data", core_ram_rdata, 32'h0000_0800);
        host_rd(11'd1824, 32'h0000_0801, "R9 new RAM data afterwards"); gap(3);
        h_rd = 1'b1; h_addr = 11'd12;
        exp_q.push_back(32'h0000_0012); due_q.push_back(cyc + 1); tag_q.push_back("R9 host reg read old data");
        core_reg_we = 1'b1; core_reg_addr = 5'd12; core_reg_wdata = 32'h0000_0C12;
        @(negedge clk); h_rd = 1'b0; core_reg_we = 1'b0;
        gap(1);
        host_rd(11'd12, 32'h0000_0C12, "R9 new reg data afterwards"); gap(1);

        // R10 stray register-side offsets
        host_wr(11'd64, 32'hDEAD_0064);
        host_rd(11'd0, 32'h0, "R10 offset 64 no alias on word 0"); gap(1);
        host_rd(11'd64, 32'h0, "R10 offset 64 reads zero"); gap(1);
        host_rd(11'd1023, 32'h0, "R10 offset 1023 reads zero"); gap(1);
        host_rd(11'd33, 32'h0, "R10 offset 33 reads zero"); gap(1);

        gap(4);
        check("R2/R3 all responses seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule